// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the divider settings for a frequency-synthesis PLL. The caller gives it a reference frequency and a requested lane rate, both in Hz, and pulses `start`. The block then walks through every pre-divider that keeps the phase-comparison frequency within a fixed window. For each one it derives a feedback divider and measures how far the resulting PLL output lands from the target. The target is twice the lane rate. When the walk ends it reports the pair with the smallest error, together with the lane rate that this pair actually produces.

All arithmetic runs through one shared iterative restoring divider, so each step costs one division pass. A full search takes a few hundred to a few thousand cycles. `done` pulses once when the outputs are valid. The outputs then hold until the next search completes. Hardware that cannot wait for the search would normally run it once at configuration time and keep the result.

Top module: `pll_div_search`

## Requirements
- R1: A `start` seen while idle begins a search. `busy` is high from the cycle after `start` until the result appears. `done` is high for exactly one cycle, and in that cycle `busy` is low.
- R2: Candidate pre-dividers run in ascending order from ceil(fref / 40 MHz) to floor(fref / 5 MHz), inclusive. A reference below 5 MHz, including zero, gives an empty range.
- R3: For a pre-divider P, the candidate feedback divider is floor(2 × lane × P / fref). A candidate below 12, above 511, or equal to 15 is skipped. The values 12 and 511 are legal.
- R4: For a legal candidate, the achieved output is floor(F × fref / P) and its error is |2 × lane − achieved|. The chosen pair has the smallest error. A later candidate replaces the current best only if its error is strictly smaller, so on a tie the smaller pre-divider wins.
- R5: When a legal candidate exists, `found` is 1, `prediv`/`fbdiv` give the chosen pair and `rate_hz` is floor(achieved / 2).
- R6: When no legal candidate exists, `found` is 0 and `rate_hz` is 0. `prediv` and `fbdiv` keep the values from the previous search (0 after reset).
- R7: A `start` pulse during a search is ignored. The running search finishes with the inputs captured at its own start.
- R8: After reset, `busy`, `done`, `found`, `prediv`, `fbdiv` and `rate_hz` are all 0.
- R9: `found`, `prediv`, `fbdiv` and `rate_hz` change only in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (used only when idle) |
| fref_hz | input | 32 | Reference frequency in Hz |
| lane_hz | input | 32 | Requested lane rate in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: result valid |
| found | output | 1 | A legal divider pair was found |
| prediv | output | 10 | Chosen pre-divider |
| fbdiv | output | 9 | Chosen feedback divider |
| rate_hz | output | 32 | Achieved lane rate in Hz (0 if none found) |

## Verification
The hardest case to reach from the ports is a pre-divider whose truncated feedback value is exactly 15. Nothing forces the search to meet it, and with most frequency pairs it never does. The bench chooses a 40 MHz reference and a 310 MHz lane rate. With these values the first pre-divider yields exactly 15, the second yields an exact match, and the skip becomes visible in the chosen pair. Boundary feedback values of 11, 12, 511 and 512 are reached the same way, using a 5 MHz reference that allows a single pre-divider. The "outputs unchanged" rule is checked by running an empty search directly after a successful one.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_MIN,
        S_MAX,
        S_FB,
        S_ACH
    } srch_state_e;
endpackage

// File: rtl/pll_srch_div.sv
module pll_srch_div #(
    parameter int NUM_W = 64,
    parameter int DEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot,
    output logic [DEN_W-1:0] rem
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] acc;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
    } div_t;

    div_t q, d;
    logic [DEN_W:0] trial;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        trial   = {q.rem, q.acc[NUM_W-1]};
        if (!q.busy) begin
            if (go) begin
                d.acc  = num;
                d.rem  = '0;
                d.den  = den;
                d.cnt  = CNT_W'(NUM_W);
                d.busy = 1'b1;
            end
        end else begin
            if (trial >= {1'b0, q.den}) begin
                d.rem = DEN_W'(trial - {1'b0, q.den});
                d.acc = {q.acc[NUM_W-2:0], 1'b1};
            end else begin
                d.rem = trial[DEN_W-1:0];
                d.acc = {q.acc[NUM_W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign done = q.done;
    assign quot = q.acc;
    assign rem  = q.rem;

    // A finished division leaves a remainder below the divisor (R3, R4 arithmetic)
    p_rem_below_den_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.den != '0) |-> (rem < q.den));
    p_done_ends_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int FREQ_W     = 32,
    parameter int PD_W       = 10,
    parameter int CMP_MIN_HZ = 5_000_000,
    parameter int CMP_MAX_HZ = 40_000_000,
    parameter int FB_MIN     = 12,
    parameter int FB_MAX     = 511,
    parameter int FB_GAP     = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] fref_hz,
    input  logic [FREQ_W-1:0] lane_hz,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [PD_W-1:0]   prediv,
    output logic [$clog2(FB_MAX+1)-1:0] fbdiv,
    output logic [FREQ_W-1:0] rate_hz
);
    localparam int FB_W = $clog2(FB_MAX + 1);
    localparam int PW   = 2 * FREQ_W;
    localparam int PC_W = PD_W + 1;
    localparam logic [PW-1:0] PD_LIMIT = PW'((1 << PD_W) - 1);

    typedef struct packed {
        srch_state_e       st;
        logic [PC_W-1:0]   pd;
        logic [PC_W-1:0]   pmin;
        logic [PC_W-1:0]   pmax;
        logic [FREQ_W-1:0] fref;
        logic [FREQ_W:0]   tgt;
        logic [FB_W-1:0]   fb_cur;
        logic              best_ok;
        logic [PD_W-1:0]   best_pd;
        logic [FB_W-1:0]   best_fb;
        logic [PW-1:0]     best_ach;
        logic [PW-1:0]     best_err;
        logic              done;
        logic              found;
        logic [PD_W-1:0]   prediv;
        logic [FB_W-1:0]   fbdiv;
        logic [FREQ_W-1:0] rate;
        logic              div_go;
        logic [PW-1:0]     div_num;
        logic [FREQ_W-1:0] div_den;
    } srch_t;

    srch_t q, d;

    logic              dv_busy, dv_done;
    logic [PW-1:0]     dv_quot;
    logic [FREQ_W-1:0] dv_rem;

    pll_srch_div #(.NUM_W(PW), .DEN_W(FREQ_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (q.div_go),
        .num   (q.div_num),
        .den   (q.div_den),
        .busy  (dv_busy),
        .done  (dv_done),
        .quot  (dv_quot),
        .rem   (dv_rem)
    );

    logic [PC_W-1:0] quot_clamped;
    logic [PC_W-1:0] pd_next;
    logic [PW-1:0]   tgt_wide;
    logic [PW-1:0]   err;
    logic            fb_bad;
    logic            fin;
    logic            advance;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.div_go = 1'b0;
        fin      = 1'b0;
        advance  = 1'b0;
        tgt_wide = PW'(q.tgt);
        quot_clamped = (dv_quot > PD_LIMIT) ? PC_W'(PD_LIMIT) : PC_W'(dv_quot);
        fb_bad   = (dv_quot < PW'(FB_MIN)) || (dv_quot > PW'(FB_MAX)) ||
                   (dv_quot == PW'(FB_GAP));
        err      = (tgt_wide >= dv_quot) ? (tgt_wide - dv_quot) : (dv_quot - tgt_wide);
        pd_next  = q.pd + 1'b1;

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.fref     = fref_hz;
                    d.tgt      = {lane_hz, 1'b0};
                    d.best_ok  = 1'b0;
                    d.best_err = '1;
                    d.div_num  = PW'(fref_hz) + PW'(CMP_MAX_HZ - 1);
                    d.div_den  = FREQ_W'(CMP_MAX_HZ);
                    d.div_go   = 1'b1;
                    d.st       = S_MIN;
                end
            end
            S_MIN: begin
                if (dv_done) begin
                    d.pmin    = quot_clamped;
                    d.pd      = quot_clamped;
                    d.div_num = PW'(q.fref);
                    d.div_den = FREQ_W'(CMP_MIN_HZ);
                    d.div_go  = 1'b1;
                    d.st      = S_MAX;
                end
            end
            S_MAX: begin
                if (dv_done) begin
                    d.pmax = quot_clamped;
                    if (q.pmin == '0 || q.pmin > quot_clamped) begin
                        fin = 1'b1;
                    end else begin
                        d.div_num = tgt_wide * PW'(q.pd);
                        d.div_den = q.fref;
                        d.div_go  = 1'b1;
                        d.st      = S_FB;
                    end
                end
            end
            S_FB: begin
                if (dv_done) begin
                    if (fb_bad) begin
                        advance = 1'b1;
                    end else begin
                        d.fb_cur  = FB_W'(dv_quot);
                        d.div_num = PW'(dv_quot[FB_W-1:0]) * PW'(q.fref);
                        d.div_den = FREQ_W'(q.pd);
                        d.div_go  = 1'b1;
                        d.st      = S_ACH;
                    end
                end
            end
            S_ACH: begin
                if (dv_done) begin
                    if (err < q.best_err) begin
                        d.best_ok  = 1'b1;
                        d.best_err = err;
                        d.best_ach = dv_quot;
                        d.best_pd  = PD_W'(q.pd);
                        d.best_fb  = q.fb_cur;
                    end
                    advance = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (advance) begin
            if (q.pd >= q.pmax) begin
                fin = 1'b1;
            end else begin
                d.pd      = pd_next;
                d.div_num = tgt_wide * PW'(pd_next);
                d.div_den = q.fref;
                d.div_go  = 1'b1;
                d.st      = S_FB;
            end
        end

        if (fin) begin
            d.st    = S_IDLE;
            d.done  = 1'b1;
            d.found = d.best_ok;
            if (d.best_ok) begin
                d.prediv = d.best_pd;
                d.fbdiv  = d.best_fb;
                d.rate   = d.best_ach[FREQ_W:1];
            end else begin
                d.rate   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = (q.st != S_IDLE);
    assign done    = q.done;
    assign found   = q.found;
    assign prediv  = q.prediv;
    assign fbdiv   = q.fbdiv;
    assign rate_hz = q.rate;

    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_fall_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    p_pd_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_ACH) |-> (q.pd != '0 && q.pd >= q.pmin && q.pd <= q.pmax));
    p_no_div_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.div_go |-> !dv_busy);
    p_fb_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (fbdiv >= FB_W'(FB_MIN) && fbdiv != FB_W'(FB_GAP)));
    p_none_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (rate_hz == '0));
    p_hold_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(found) && $stable(prediv) && $stable(fbdiv) && $stable(rate_hz)));
endmodule

// File: tb/tb_pll_div_search.sv
module tb_pll_div_search;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] fref_hz = '0;
    logic [31:0] lane_hz = '0;
    logic        busy, done, found;
    logic [9:0]  prediv;
    logic [8:0]  fbdiv;
    logic [31:0] rate_hz;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    pll_div_search dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .fref_hz(fref_hz), .lane_hz(lane_hz),
        .busy(busy), .done(done), .found(found),
        .prediv(prediv), .fbdiv(fbdiv), .rate_hz(rate_hz)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Search computed from the requirements (R2, R3, R4, R5)
    task automatic model(input longint unsigned fr, input longint unsigned ln,
                         output bit ok, output longint unsigned pd_o,
                         output longint unsigned fb_o, output longint unsigned rate_o);
        longint unsigned tgt = 2 * ln;
        longint unsigned lo = (fr + 39999999) / 40000000;
        longint unsigned hi = fr / 5000000;
        longint unsigned best = 64'hFFFF_FFFF_FFFF_FFFF;
        ok = 0; pd_o = 0; fb_o = 0; rate_o = 0;
        if (fr == 0) return;
        for (longint unsigned p = lo; p <= hi; p++) begin
            longint unsigned f = tgt * p / fr;
            longint unsigned a, e;
            if (f < 12 || f > 511 || f == 15) continue;
            a = f * fr / p;
            e = (tgt > a) ? tgt - a : a - tgt;
            if (e < best) begin
                best = e; ok = 1; pd_o = p; fb_o = f; rate_o = a / 2;
            end
        end
    endtask

    task automatic pulse_start(input logic [31:0] fr, input logic [31:0] ln);
        @(negedge clk);
        fref_hz = fr; lane_hz = ln; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check(req, "done reached", done, 1);
    endtask

    task automatic run_search(input string name, input logic [31:0] fr, input logic [31:0] ln,
                              input longint unsigned old_pd, input longint unsigned old_fb);
        bit ok;
        longint unsigned ep, ef, er;
        model(fr, ln, ok, ep, ef, er);
        pulse_start(fr, ln);
        check("R1", {name, " busy after start"}, busy, 1);
        wait_done("R1");
        check("R1", {name, " busy low at done"}, busy, 0);
        check("R5", {name, " found"}, found, ok);
        if (ok) begin
            check("R4", {name, " prediv"}, prediv, ep);
            check("R3", {name, " fbdiv"}, fbdiv, ef);
            check("R5", {name, " rate"}, rate_hz, er);
        end else begin
            check("R6", {name, " rate zero"}, rate_hz, 0);
            check("R6", {name, " prediv held"}, prediv, old_pd);
            check("R6", {name, " fbdiv held"}, fbdiv, old_fb);
        end
        @(negedge clk);
        check("R1", {name, " done one cycle"}, done, 0);
        check("R9", {name, " rate held after done"}, rate_hz, ok ? er : 0);
    endtask

    task automatic t_reset();
        check("R8", "busy", busy, 0);
        check("R8", "done", done, 0);
        check("R8", "found", found, 0);
        check("R8", "prediv", prediv, 0);
        check("R8", "fbdiv", fbdiv, 0);
        check("R8", "rate", rate_hz, 0);
    endtask

    task automatic t_exact_match();
        // 24 MHz ref, 500 MHz lane: P=3, F=125 exact (R4)
        run_search("exact", 32'd24_000_000, 32'd500_000_000, 0, 0);
        check("R4", "exact prediv value", prediv, 3);
        check("R4", "exact fbdiv value", fbdiv, 125);
        check("R5", "exact rate value", rate_hz, 500_000_000);
    endtask

    task automatic t_gap_skip();
        // 40 MHz ref, 310 MHz lane: P=1 gives F=15 (skipped), P=2 gives 31
        run_search("gap", 32'd40_000_000, 32'd310_000_000, 3, 125);
        check("R3", "gap skipped prediv", prediv, 2);
        check("R3", "gap skipped fbdiv", fbdiv, 31);
    endtask

    task automatic t_varied();
        run_search("ref27", 32'd27_000_000, 32'd445_500_000, 2, 31);
        run_search("ref100", 32'd100_000_000, 32'd333_333_333, prediv, fbdiv);
        run_search("ref19p2", 32'd19_200_000, 32'd912_000_000, prediv, fbdiv);
    endtask

    task automatic t_fb_bounds();
        logic [9:0] hp;
        logic [8:0] hf;
        run_search("fb512", 32'd5_000_000, 32'd1_280_000_000, prediv, fbdiv);
        check("R3", "fb 512 rejected", found, 0);
        run_search("fb511", 32'd5_000_000, 32'd1_277_500_000, prediv, fbdiv);
        check("R3", "fb 511 accepted", fbdiv, 511);
        run_search("fb12", 32'd5_000_000, 32'd30_000_000, prediv, fbdiv);
        check("R3", "fb 12 accepted", fbdiv, 12);
        hp = prediv; hf = fbdiv;
        run_search("fb11", 32'd5_000_000, 32'd27_500_000, hp, hf);
        check("R3", "fb 11 rejected", found, 0);
    endtask

    task automatic t_empty_ranges();
        logic [9:0] hp;
        logic [8:0] hf;
        run_search("ok_before", 32'd24_000_000, 32'd500_000_000, prediv, fbdiv);
        hp = prediv; hf = fbdiv;
        run_search("ref4M", 32'd4_000_000, 32'd500_000_000, hp, hf);
        check("R2", "sub-window ref no pair", found, 0);
        run_search("ref0", 32'd0, 32'd500_000_000, hp, hf);
        check("R2", "zero ref no pair", found, 0);
        run_search("all_small", 32'd40_000_000, 32'd1_000_000, hp, hf);
        check("R6", "all small fb no pair", found, 0);
    endtask

    task automatic t_start_while_busy();
        pulse_start(32'd24_000_000, 32'd500_000_000);
        repeat (20) @(negedge clk);
        start = 1'b1; fref_hz = 32'd40_000_000; lane_hz = 32'd1_000_000;
        @(negedge clk);
        start = 1'b0;
        wait_done("R7");
        check("R7", "ignored start found", found, 1);
        check("R7", "ignored start prediv", prediv, 3);
        check("R7", "ignored start rate", rate_hz, 500_000_000);
        @(negedge clk);
        check("R7", "idle after search", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_exact_match();
        t_gap_skip();
        t_varied();
        t_fb_bounds();
        t_empty_ranges();
        t_start_while_busy();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cycles >= 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule